// File: doc/BRIEF.md
# Dual-Channel Serial DAC Control Logic

This block is the digital front end of a two-channel 10-bit voltage-output converter. A host shifts a 16-bit command word in over a three-wire serial link: an active-low select that doubles as the load strobe, a serial clock and a data line. When the select returns high, the block decodes a 4-bit command field and acts on it. The command can load one or both channel input registers, copy the input registers into the output registers, or put the converter to sleep and wake it up.

Each channel is double-buffered. Its input register takes new codes, and its output register drives the converter. Both output registers are always refreshed together, which gives glitch-free simultaneous updates. While the part sleeps, the outputs are marked high-impedance and a power-down flag is raised. The input registers can still be written during sleep. A single update command then wakes the part and applies the new codes at once.

The serial pins are sampled in the system clock domain through a short synchronizer. The serial clock must therefore run well below the system clock: each serial level has to be held for several system clocks.

Top module: `dual_dac_ctrl`

## Requirements
- R1: After reset, both output codes are 0, both output enables are 1 and the power-down flag is 0.
- R2: While the select is low, each rising serial-clock edge shifts one data bit into a 16-bit register. The word is sent most significant bit first and is laid out as follows. Bits 15..12 hold the command. Bits 11..2 hold the 10-bit code. Bits 1..0 are ignored.
- R3: A command executes only on the rising edge of the select. While a word is being shifted, the outputs keep their values.
- R4: Command 0001 writes input register A, and command 0010 writes input register B. Neither changes the output codes or the sleep state.
- R5: Command 1000 copies both input registers into both output registers and wakes the part.
- R6: Command 1001 writes input A and command 1010 writes input B. Each then copies both input registers into the output registers, which carry the new value plus the other channel's held value, and wakes the part.
- R7: Command 1111 writes the same code into both input registers, updates both outputs and wakes the part.
- R8: Command 1110 enters sleep: both output enables go to 0 and the power-down flag goes to 1. All registers are kept and the code field is ignored. Command 1101 wakes the part without changing any register.
- R9: Commands 0001 and 0010 issued during sleep do not wake the part. A later 1000 wakes it with the new codes.
- R10: Command 0000 and the reserved commands 0011, 0100, 0101, 0110, 0111, 1011 and 1100 change no register and leave the sleep state unchanged.
- R11: If more than 16 serial-clock edges arrive while the select is low, the last 16 bits shifted in are decoded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_ld | input | 1 | Serial select (active low); its rising edge executes the command |
| sck | input | 1 | Serial clock; data is captured on its rising edge |
| din | input | 1 | Serial data in |
| dac_a | output | 10 | Channel A output register |
| dac_b | output | 10 | Channel B output register |
| oe_a | output | 1 | Channel A output enable (0 = high-impedance) |
| oe_b | output | 1 | Channel B output enable (0 = high-impedance) |
| pwr_down | output | 1 | Analog power-down flag (1 = sleep) |

## Verification
The hardest state to reach is a sleep in which the input registers hold values that differ from the output registers. Here a wrong decode that wakes the part, or that copies the codes early, is invisible until a later command acts. The bench gets there by sending a sleep command, then channel loads with new codes, and checks that the outputs and the flag are unchanged. It then sends a plain update and checks that the new codes appear together with the wake. Over-long words are covered by sending garbage bits ahead of a valid word. Mid-word stability is covered by sampling the outputs before each select rise.

// File: rtl/dual_dac_ctrl.sv
module dual_dac_ctrl #(
  parameter int DATA_W      = 10,
  parameter int CODE_W      = 4,
  parameter int PAD_W       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_ld,
  input  logic              sck,
  input  logic              din,
  output logic [DATA_W-1:0] dac_a,
  output logic [DATA_W-1:0] dac_b,
  output logic              oe_a,
  output logic              oe_b,
  output logic              pwr_down
);
  localparam int WORD_W = CODE_W + DATA_W + PAD_W;

  logic [SYNC_STAGES-1:0] cs_sync, sck_sync, din_sync;
  logic s_cs, s_sck, s_din;
  logic prev_cs, prev_sck;
  logic sck_rise, ld_pulse;
  logic [WORD_W-1:0] shreg;
  logic [CODE_W-1:0] cmd;
  logic [DATA_W-1:0] arg;
  logic [DATA_W-1:0] in_a, in_b;
  logic sleep;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) begin
          cs_sync <= '1; sck_sync <= '0; din_sync <= '0;
        end else begin
          cs_sync <= cs_ld; sck_sync <= sck; din_sync <= din;
        end
    end else begin : g_syncn
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) begin
          cs_sync <= '1; sck_sync <= '0; din_sync <= '0;
        end else begin
          cs_sync  <= {cs_sync[SYNC_STAGES-2:0], cs_ld};
          sck_sync <= {sck_sync[SYNC_STAGES-2:0], sck};
          din_sync <= {din_sync[SYNC_STAGES-2:0], din};
        end
    end
  endgenerate

  assign s_cs  = cs_sync[SYNC_STAGES-1];
  assign s_sck = sck_sync[SYNC_STAGES-1];
  assign s_din = din_sync[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      prev_cs  <= 1'b1;
      prev_sck <= 1'b0;
    end else begin
      prev_cs  <= s_cs;
      prev_sck <= s_sck;
    end

  assign sck_rise = s_sck & ~prev_sck & ~s_cs;
  assign ld_pulse = s_cs & ~prev_cs;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        shreg <= '0;
    else if (sck_rise) shreg <= {shreg[WORD_W-2:0], s_din};

  assign cmd = shreg[WORD_W-1 -: CODE_W];
  assign arg = shreg[WORD_W-CODE_W-1 -: DATA_W];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      in_a  <= '0;
      in_b  <= '0;
      dac_a <= '0;
      dac_b <= '0;
      sleep <= 1'b0;
    end else if (ld_pulse) begin
      case (cmd)
        4'b0001: in_a <= arg;
        4'b0010: in_b <= arg;
        4'b1000: begin
          dac_a <= in_a; dac_b <= in_b; sleep <= 1'b0;
        end
        4'b1001: begin
          in_a <= arg; dac_a <= arg; dac_b <= in_b; sleep <= 1'b0;
        end
        4'b1010: begin
          in_b <= arg; dac_a <= in_a; dac_b <= arg; sleep <= 1'b0;
        end
        4'b1101: sleep <= 1'b0;
        4'b1110: sleep <= 1'b1;
        4'b1111: begin
          in_a <= arg; in_b <= arg; dac_a <= arg; dac_b <= arg; sleep <= 1'b0;
        end
        default: ;
      endcase
    end

  assign pwr_down = sleep;
  assign oe_a     = ~sleep;
  assign oe_b     = ~sleep;
endmodule

module dual_dac_ctrl_chk #(
  parameter int DATA_W = 10,
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ld_pulse,
  input logic              s_cs,
  input logic [WORD_W-1:0] shreg,
  input logic [DATA_W-1:0] dac_a,
  input logic [DATA_W-1:0] dac_b,
  input logic              pwr_down
);
  assert_shift_only_selected_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(shreg) |-> $past(!s_cs));
  assert_dac_a_only_on_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dac_a) |-> $past(ld_pulse));
  assert_dac_b_only_on_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dac_b) |-> $past(ld_pulse));
  assert_update_wakes_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(dac_a) || !$stable(dac_b)) |-> !pwr_down);
  assert_sleep_on_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwr_down) |-> $past(ld_pulse));
  assert_sleep_keeps_codes_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwr_down) |-> ($stable(dac_a) && $stable(dac_b)));
endmodule

bind dual_dac_ctrl dual_dac_ctrl_chk #(.DATA_W(DATA_W), .WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ld_pulse(ld_pulse), .s_cs(s_cs), .shreg(shreg),
  .dac_a(dac_a), .dac_b(dac_b), .pwr_down(pwr_down)
);

// File: tb/dual_dac_ctrl_bench.sv
module dual_dac_ctrl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_ld = 1'b1, sck = 1'b0, din = 1'b0;
  logic [9:0] dac_a, dac_b;
  logic oe_a, oe_b, pwr_down;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [9:0] m_ia = '0, m_ib = '0, m_da = '0, m_db = '0;
  logic m_sl = 1'b0;

  always #5 clk = ~clk;

  dual_dac_ctrl u_dual_dac_ctrl (
    .clk(clk), .rst_n(rst_n), .cs_ld(cs_ld), .sck(sck), .din(din),
    .dac_a(dac_a), .dac_b(dac_b), .oe_a(oe_a), .oe_b(oe_b), .pwr_down(pwr_down)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic cmp(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    cmp({tag, " dac_a"}, 32'(dac_a), 32'(m_da));
    cmp({tag, " dac_b"}, 32'(dac_b), 32'(m_db));
    cmp({tag, " oe_a"}, 32'(oe_a), 32'(!m_sl));
    cmp({tag, " oe_b"}, 32'(oe_b), 32'(!m_sl));
    cmp({tag, " pwr_down"}, 32'(pwr_down), 32'(m_sl));
  endtask

  task automatic model(input logic [3:0] c, input logic [9:0] d);
    case (c)
      4'b0001: m_ia = d;
      4'b0010: m_ib = d;
      4'b1000: begin m_da = m_ia; m_db = m_ib; m_sl = 0; end
      4'b1001: begin m_ia = d; m_da = m_ia; m_db = m_ib; m_sl = 0; end
      4'b1010: begin m_ib = d; m_da = m_ia; m_db = m_ib; m_sl = 0; end
      4'b1101: m_sl = 0;
      4'b1110: m_sl = 1;
      4'b1111: begin m_ia = d; m_ib = d; m_da = d; m_db = d; m_sl = 0; end
      default: ;
    endcase
  endtask

  task automatic shift_bit(input logic b);
    din = b; tick(4);
    sck = 1'b1; tick(4);
    sck = 1'b0;
  endtask

  task automatic send(input logic [3:0] c, input logic [9:0] d, input logic [1:0] xb,
                      input int pre, input string tag);
    logic [15:0] w;
    w = {c, d, xb};
    cs_ld = 1'b0; tick(4);
    for (int i = 0; i < pre; i++) shift_bit(i[0] ^ i[2]);
    for (int i = 15; i >= 0; i--) shift_bit(w[i]);
    tick(6);
    check_all({tag, " R3 mid-word"});
    cs_ld = 1'b1;
    model(c, d);
    tick(10);
    check_all(tag);
  endtask

  task automatic t_reset;
    check_all("R1 reset");
  endtask

  task automatic t_load_then_update;
    send(4'b0001, 10'h155, 2'b11, 0, "R4 load A");
    send(4'b0010, 10'h2AA, 2'b00, 0, "R4 load B");
    send(4'b1000, 10'h3FF, 2'b10, 0, "R5 update");
    cmp("R2 field order A", 32'(dac_a), 32'h155);
    cmp("R2 field order B", 32'(dac_b), 32'h2AA);
  endtask

  task automatic t_load_and_update;
    send(4'b1001, 10'h201, 2'b01, 0, "R6 load+update A");
    send(4'b1010, 10'h001, 2'b11, 0, "R6 load+update B");
  endtask

  task automatic t_broadcast;
    send(4'b1111, 10'h3C3, 2'b00, 0, "R7 broadcast");
  endtask

  task automatic t_sleep_wake;
    send(4'b1110, 10'h0F0, 2'b11, 0, "R8 sleep");
    send(4'b0001, 10'h011, 2'b00, 0, "R9 load A asleep");
    send(4'b0010, 10'h322, 2'b00, 0, "R9 load B asleep");
    send(4'b1000, 10'h000, 2'b00, 0, "R9 wake update");
    send(4'b1110, 10'h3FF, 2'b00, 0, "R8 sleep again");
    send(4'b1101, 10'h3FF, 2'b00, 0, "R8 wake only");
  endtask

  task automatic t_reserved;
    logic [3:0] rsv [8] = '{4'b0000, 4'b0011, 4'b0100, 4'b0101,
                            4'b0110, 4'b0111, 4'b1011, 4'b1100};
    send(4'b0001, 10'h0AA, 2'b00, 0, "R10 preload A");
    for (int i = 0; i < 8; i++) send(rsv[i], 10'h3A5, 2'b11, 0, "R10 reserved");
    send(4'b1000, 10'h000, 2'b00, 0, "R10 update after reserved");
    send(4'b1110, 10'h000, 2'b00, 0, "R10 sleep");
    send(4'b0111, 10'h1FF, 2'b00, 0, "R10 reserved asleep");
    send(4'b1101, 10'h000, 2'b00, 0, "R10 wake");
  endtask

  task automatic t_overlong;
    send(4'b1111, 10'h2D4, 2'b01, 7, "R11 seven extra leading bits");
    send(4'b1001, 10'h04B, 2'b10, 16, "R11 sixteen extra leading bits");
  endtask

  initial begin
    tick(5);
    rst_n = 1'b1;
    tick(5);
    t_reset();
    t_load_then_update();
    t_load_and_update();
    t_broadcast();
    t_sleep_wake();
    t_reserved();
    t_overlong();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule